// File: doc/BRIEF.md
# Byte-Stream Instruction Prefetch Unit

This block fetches instruction bytes ahead of an execution datapath. It keeps its own fetch word pointer and asks a word-wide instruction memory for the next 32-bit word whenever its byte buffer has room for a whole word. It unpacks each returned word into a shift register of bytes. Because the block advances the program counter itself, the main ALU never has to step the program counter or build operands out of single bytes.

The datapath reads from two ports. The byte port shows the oldest byte that has not yet been consumed. The operand port shows the two oldest bytes joined into one 16-bit value. Asserting a port's read strobe while that port is valid consumes its bytes at the next clock edge, and the program counter moves forward by the same count. For a jump, a redirect input loads a new program counter and flushes the buffer. Fetching then restarts from the word that contains the new address, and any bytes in that word below the target are dropped.

Top module: `byte_prefetch_unit`

## Requirements
- R1: After reset both port valid flags are low, the program counter output is 0, and the first memory request is for word address 0.
- R2: When the byte port is valid it shows the byte at the program counter address. Memory byte order: byte address 4w+i is bits [8i+7:8i] of the data word returned for word address w.
- R3: When the operand port is valid it shows {byte at PC, byte at PC+1}, with the byte at PC in bits [15:8].
- R4: A byte-port read while the byte port is valid, with no operand read, consumes one byte and raises the program counter by 1 at the next edge.
- R5: An operand read while the operand port is valid consumes two bytes and raises the program counter by 2. If both strobes are high together, the operand read wins and the byte strobe is ignored.
- R6: The byte port is valid when at least one byte is buffered, and the operand port when at least two are. A read of a port that is not valid consumes nothing and leaves the program counter unchanged. If the operand read is not valid but the byte read is, the byte read proceeds.
- R7: A memory request is issued only when at least 4 of the 8 byte slots are free and no request is outstanding. Successive requests go to consecutive word addresses. With no reads after reset, exactly two requests are issued.
- R8: At most one request is outstanding. No new request is issued before the response to the previous one has arrived.
- R9: A redirect sets the program counter to the target at the next edge and empties the buffer. The next request goes to word target/4, and the first valid byte is the byte at the target.
- R10: A response that arrives for a request issued before a redirect is discarded and never reaches either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_i | input | 1 | Redirect strobe |
| redir_pc_i | input | ADDR_W | Redirect target byte address |
| mem_req_o | output | 1 | Word fetch request, taken at the clock edge |
| mem_word_o | output | ADDR_W-2 | Word address of the request |
| mem_rvalid_i | input | 1 | Response data valid |
| mem_rdata_i | input | 32 | Response data word |
| byte_rd_i | input | 1 | Consume one byte |
| byte_vld_o | output | 1 | Byte port valid |
| byte_o | output | 8 | Oldest buffered byte |
| opnd_rd_i | input | 1 | Consume two bytes |
| opnd_vld_o | output | 1 | Operand port valid |
| opnd_o | output | 16 | Two oldest bytes, first byte high |
| pc_o | output | ADDR_W | Address of the oldest unconsumed byte |

## Verification
A wrong buffer fill level or slot shift shows up on the read ports. The byte or operand value stops matching the byte expected at the program counter, and this is visible in the same cycle the bad entry reaches slot 0, so every valid cycle of a long read stream compares both ports with a byte function of the address. A wrong fetch pointer or skip count gives data from the wrong address on the first valid cycle after a redirect. A lost or duplicated outstanding-request flag shows up one edge later, either as a protocol violation at the memory model or as stale bytes from a dropped response.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
   typedef logic [7:0] byte_t;

   // Number of bytes consumed by the read strobes in one cycle
   typedef logic [1:0] pop_t;

   function automatic pop_t pick_pop(input logic rd1, input logic rd2,
                                     input logic v1, input logic v2);
      if (rd2 && v2)      return 2'd2;
      else if (rd1 && v1) return 2'd1;
      else                return 2'd0;
   endfunction
endpackage

// File: rtl/pfu_fetch_ctl.sv
module pfu_fetch_ctl #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 8,
   parameter int WB     = 4,
   localparam int OFF_W = $clog2(WB),
   localparam int WAW   = ADDR_W - OFF_W,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir_i,
   input  logic [ADDR_W-1:0] redir_pc_i,
   input  logic [CW-1:0]     used_i,
   input  logic              rvalid_i,
   output logic              req_o,
   output logic [WAW-1:0]    word_o,
   output logic              push_o,
   output logic [OFF_W-1:0]  skip_o
);
   logic             pend_q, drop_q;
   logic [WAW-1:0]   word_q;
   logic [OFF_W-1:0] skip_q;

   assign req_o  = rst_n && !pend_q && !redir_i && (int'(used_i) <= DEPTH - WB);
   assign push_o = pend_q && rvalid_i && !drop_q && !redir_i;
   assign word_o = word_q;
   assign skip_o = skip_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         drop_q <= 1'b0;
         word_q <= '0;
         skip_q <= '0;
      end else if (redir_i) begin
         word_q <= redir_pc_i[ADDR_W-1:OFF_W];
         skip_q <= redir_pc_i[OFF_W-1:0];
         pend_q <= pend_q && !rvalid_i;
         drop_q <= pend_q && !rvalid_i;
      end else begin
         if (req_o) begin
            pend_q <= 1'b1;
            word_q <= word_q + WAW'(1);
         end
         if (pend_q && rvalid_i) begin
            pend_q <= 1'b0;
            drop_q <= 1'b0;
            if (!drop_q) skip_q <= '0;
         end
      end
   end

   // R8: a request edge leaves the unit busy on the next cycle
   p_single_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |=> !req_o);
   // R10: a response that was already in flight at a redirect is not written
   p_drop_stale_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_i && pend_q && !rvalid_i) |=> !push_o);
endmodule

// File: rtl/pfu_byte_fifo.sv
module pfu_byte_fifo
   import pfu_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter int WB          = 4,
   parameter bit OP_MSB_FIRST = 1'b1,
   localparam int OFF_W = $clog2(WB),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            rd1_i,
   input  logic            rd2_i,
   input  logic            push_i,
   input  logic [8*WB-1:0] word_i,
   input  logic [OFF_W-1:0] skip_i,
   output logic [CW-1:0]   count_o,
   output logic            v1_o,
   output logic [7:0]      d1_o,
   output logic            v2_o,
   output logic [15:0]     d2_o,
   output pop_t            pop_o
);
   byte_t         q_q [DEPTH];
   byte_t         q_d [DEPTH];
   logic [CW-1:0] cnt_q, cnt_d;

   assign v1_o    = cnt_q != '0;
   assign v2_o    = int'(cnt_q) >= 2;
   assign count_o = cnt_q;
   assign d1_o    = q_q[0];
   assign pop_o   = pick_pop(rd1_i, rd2_i, v1_o, v2_o);

   generate
      if (OP_MSB_FIRST) begin : g_op_be
         assign d2_o = {q_q[0], q_q[1]};
      end else begin : g_op_le
         assign d2_o = {q_q[1], q_q[0]};
      end
   endgenerate

   always_comb begin
      int base;
      int npush;
      int src;
      int rel;
      base  = int'(cnt_q) - int'(pop_o);
      npush = push_i ? (WB - int'(skip_i)) : 0;
      for (int i = 0; i < DEPTH; i++) begin
         src = i + int'(pop_o);
         q_d[i] = '0;
         if (src < DEPTH) q_d[i] = q_q[src];
         rel = i - base;
         if (rel >= 0 && rel < npush) q_d[i] = word_i[(int'(skip_i) + rel)*8 +: 8];
      end
      cnt_d = CW'(base + npush);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
      end else if (flush_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         for (int i = 0; i < DEPTH; i++) q_q[i] <= q_d[i];
      end
   end

   // R7: a pushed word always fits in the free slots
   always_comb begin
      if (rst_n === 1'b1 && push_i)
         p_no_overflow_r7: assert (int'(cnt_q) - int'(pop_o) + WB - int'(skip_i) <= DEPTH);
   end
endmodule

// File: rtl/byte_prefetch_unit.sv
module byte_prefetch_unit
   import pfu_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 8,
   parameter int WB     = 4,
   localparam int OFF_W = $clog2(WB),
   localparam int WAW   = ADDR_W - OFF_W,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redir_i,
   input  logic [ADDR_W-1:0] redir_pc_i,
   output logic              mem_req_o,
   output logic [WAW-1:0]    mem_word_o,
   input  logic              mem_rvalid_i,
   input  logic [8*WB-1:0]   mem_rdata_i,
   input  logic              byte_rd_i,
   output logic              byte_vld_o,
   output logic [7:0]        byte_o,
   input  logic              opnd_rd_i,
   output logic              opnd_vld_o,
   output logic [15:0]       opnd_o,
   output logic [ADDR_W-1:0] pc_o
);
   generate
      if (WB < 2 || (WB & (WB - 1)) != 0) begin : g_bad_wb
         $error("word byte count must be a power of two of at least 2");
      end
      if (DEPTH < WB || DEPTH < 2) begin : g_bad_depth
         $error("buffer must hold at least one word");
      end
   endgenerate

   logic [CW-1:0]    used;
   logic             push;
   logic [OFF_W-1:0] skip;
   pop_t             pop_n;
   logic [ADDR_W-1:0] pc_q;

   pfu_fetch_ctl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WB(WB)) u_fetch (
      .clk(clk), .rst_n(rst_n), .redir_i(redir_i), .redir_pc_i(redir_pc_i),
      .used_i(used), .rvalid_i(mem_rvalid_i), .req_o(mem_req_o),
      .word_o(mem_word_o), .push_o(push), .skip_o(skip));

   pfu_byte_fifo #(.DEPTH(DEPTH), .WB(WB), .OP_MSB_FIRST(1'b1)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush_i(redir_i), .rd1_i(byte_rd_i),
      .rd2_i(opnd_rd_i), .push_i(push), .word_i(mem_rdata_i), .skip_i(skip),
      .count_o(used), .v1_o(byte_vld_o), .d1_o(byte_o), .v2_o(opnd_vld_o),
      .d2_o(opnd_o), .pop_o(pop_n));

   always_ff @(posedge clk) begin
      if (!rst_n)       pc_q <= '0;
      else if (redir_i) pc_q <= redir_pc_i;
      else              pc_q <= pc_q + ADDR_W'(pop_n);
   end
   assign pc_o = pc_q;

   p_pc_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_i && opnd_rd_i && opnd_vld_o) |=> pc_o == $past(pc_o) + ADDR_W'(2));
   p_pc_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_i && byte_rd_i && byte_vld_o && !opnd_rd_i) |=> pc_o == $past(pc_o) + ADDR_W'(1));
   p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_i && !(byte_rd_i && byte_vld_o) && !(opnd_rd_i && opnd_vld_o)) |=> $stable(pc_o));
   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redir_i |=> (!byte_vld_o && pc_o == $past(redir_pc_i)));
   p_ports_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_vld_o |-> byte_vld_o);
endmodule

// File: tb/test_byte_prefetch_unit.sv
`timescale 1ns/100ps
module test_byte_prefetch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redir_i = 1'b0;
   logic [15:0] redir_pc_i = '0;
   logic        mem_req_o;
   logic [13:0] mem_word_o;
   logic        mem_rvalid_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        byte_rd_i = 1'b0, opnd_rd_i = 1'b0;
   logic        byte_vld_o, opnd_vld_o;
   logic [7:0]  byte_o;
   logic [15:0] opnd_o, pc_o;

   int checks = 0, errors = 0;
   int pc_exp = 0, exp_word = 0, lat = 1, reqs = 0, cycles = 0;
   bit busy = 0;
   int m_addr = 0, m_cnt = 0;
   string tagpc = "R1";

   always #2 clk = ~clk;

   byte_prefetch_unit i_byte_prefetch_unit (.*);

   function automatic logic [7:0] fb(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   function automatic logic [31:0] wordf(int w);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = fb(4*w + i);
      return r;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: one request at a time, fixed latency
   always @(negedge clk) begin
      #1.0;
      mem_rvalid_i = 1'b0;
      if (!rst_n) busy = 0;
      else begin
         if (busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               mem_rvalid_i = 1'b1;
               mem_rdata_i = wordf(m_addr);
               busy = 0;
            end
         end
         if (mem_req_o) begin
            chk(!busy, "R8 request while busy", 1, 0);
            chk(int'(mem_word_o) == exp_word, "R7/R1/R9 request word", int'(mem_word_o), exp_word);
            exp_word = (exp_word + 1) & 16'h3fff;
            busy = 1; m_addr = int'(mem_word_o); m_cnt = lat; reqs++;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic do_redirect(int target);
      @(negedge clk); #0.5;
      redir_i = 1'b1; redir_pc_i = 16'(target);
      byte_rd_i = 1'b0; opnd_rd_i = 1'b0;
      pc_exp = target; exp_word = target >> 2;
      @(negedge clk); #0.5;
      redir_i = 1'b0;
      chk(!byte_vld_o && !opnd_vld_o, "R9 buffer empty after redirect", byte_vld_o, 0);
      chk(pc_o == 16'(target), "R9 pc loaded", pc_o, target);
   endtask

   task automatic run_stream(int mode, int n);
      int done = 0;
      int cyc = 0;
      bit r1, r2;
      while (done < n) begin
         @(negedge clk); #0.5;
         chk(pc_o == 16'(pc_exp), tagpc, pc_o, pc_exp);
         if (byte_vld_o) chk(byte_o == fb(pc_exp), "R2 byte port", byte_o, fb(pc_exp));
         if (opnd_vld_o) chk(opnd_o == {fb(pc_exp), fb(pc_exp + 1)}, "R3 operand port",
                             opnd_o, {fb(pc_exp), fb(pc_exp + 1)});
         case (mode)
            0: begin r1 = 1; r2 = 0; end
            1: begin r1 = 0; r2 = 1; end
            2: begin r1 = cyc[0]; r2 = !cyc[0]; end
            3: begin r1 = 1; r2 = 1; end
            default: begin r1 = (cyc % 3 == 0) && ((cyc / 3) % 2 == 0);
                           r2 = (cyc % 3 == 0) && ((cyc / 3) % 2 == 1); end
         endcase
         byte_rd_i = r1; opnd_rd_i = r2;
         if (r2 && opnd_vld_o) begin pc_exp += 2; done++; tagpc = "R5 pc step"; end
         else if (r1 && byte_vld_o) begin pc_exp += 1; done++; tagpc = r2 ? "R6 byte read proceeds" : "R4 pc step"; end
         else tagpc = (r1 || r2) ? "R6 invalid read" : "R4 pc idle";
         cyc++;
      end
      @(negedge clk); #0.5;
      chk(pc_o == 16'(pc_exp), tagpc, pc_o, pc_exp);
      byte_rd_i = 1'b0; opnd_rd_i = 1'b0;
      tagpc = "R4 pc idle";
   endtask

   initial begin
      int r0;
      repeat (3) @(negedge clk);
      #0.5;
      rst_n = 1'b1;
      chk(!byte_vld_o && !opnd_vld_o, "R1 valids low after reset", byte_vld_o, 0);
      chk(pc_o == 16'h0, "R1 pc after reset", pc_o, 0);
      repeat (30) @(negedge clk);
      #0.5;
      chk(reqs == 2, "R7 idle request count", reqs, 2);
      chk(opnd_vld_o && opnd_o == {fb(0), fb(1)}, "R3 operand at address 0", opnd_o, {fb(0), fb(1)});

      // offset redirect with no reads: 1 + 4 bytes fit, then fetching stops
      r0 = reqs;
      do_redirect(16'h0123);
      repeat (30) @(negedge clk);
      #0.5;
      chk(reqs - r0 == 2, "R7 request count after offset redirect", reqs - r0, 2);
      chk(byte_vld_o && byte_o == fb(16'h0123), "R9 first byte skips leading bytes", byte_o, fb(16'h0123));

      for (int l = 1; l <= 5; l++) begin
         for (int m = 0; m <= 4; m++) begin
            lat = l;
            do_redirect(16'h40 + l * 13 + m * 3);
            run_stream(m, 24);
         end
      end

      // R10: redirect while a fetch is outstanding
      lat = 7;
      do_redirect(16'h0200);
      @(negedge clk);
      do_redirect(16'h0305);
      while (!byte_vld_o) begin @(negedge clk); #0.5; end
      chk(byte_o == fb(16'h0305), "R10 stale response dropped", byte_o, fb(16'h0305));
      run_stream(2, 20);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule